// File: doc/BRIEF.md
# Paged Display Memory Streamer

This block pushes one complete frame of pixel bytes into a page-organised LCD controller. It works through the pages in order. For each page it emits three command bytes that position the controller's write pointer: the page number, then the upper column nibble, then the lower column nibble. A burst of one data byte per column follows. Every byte leaves on a byte-writer interface: a byte, a flag that tells command (low) from display data (high), and a valid/ready handshake. The serial shifter that consumes this interface sits outside the block.

Three sources can fill the data bytes. Blank mode writes zeros. Stripe mode writes bands eight columns wide that alternate between all-dark and all-clear. Buffer mode fetches each byte from a synchronous frame memory. A single-cycle start pulse latches the source and begins a frame. A single-cycle done pulse reports that the last data byte has been taken.

Top module: `page_frame_streamer`

## Requirements
- R1: While rst_n is low and on the first cycle after it, wr_valid_o, done_o, busy_o and mem_rd_en_o are all low.
- R2: Each page begins with three command bytes, each with wr_a0_o low: 0xB0 OR-ed with bits [3:0] of the page number, then 0x10 (upper nibble of column 0), then 0x00 (lower nibble of column 0). These are followed by NUM_COLS data bytes with wr_a0_o high.
- R3: Pages go out in increasing order from 0 to NUM_PAGES-1, and columns within a page in increasing order from 0. A frame is exactly NUM_PAGES*(NUM_COLS+3) handshakes long.
- R4: mode_i = 2'b00 (blank) and mode_i = 2'b11 both send 0x00 for every data byte.
- R5: mode_i = 2'b01 (stripe) sends 0xFF for a column whose bit 3 is set, and 0x00 otherwise. Columns 0-7 are clear, 8-15 are dark, and so on.
- R6: mode_i = 2'b10 (buffer) sends for column c of page p the memory byte at address p*NUM_COLS+c. The memory returns rd_data the cycle after mem_rd_en_o. mem_rd_en_o is never high in any other mode.
- R7: While wr_valid_o is high and wr_ready_i is low, wr_valid_o stays high and wr_byte_o and wr_a0_o hold their values.
- R8: done_o is high for exactly one cycle, the cycle after the handshake of the final data byte. busy_o is high from the cycle after an accepted start until that done cycle, and it is low during the done cycle.
- R9: A start pulse that arrives while busy_o is high is ignored. The frame in progress and its mode carry on unchanged.
- R10: mode_i is sampled only with an accepted start. Changes to it during a frame have no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a frame (ignored while busy) |
| mode_i | input | 2 | Data source: 00 blank, 01 stripe, 10 buffer, 11 blank |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the final data byte |
| mem_rd_en_o | output | 1 | Frame memory read strobe |
| mem_rd_addr_o | output | ADDR_W | Frame memory byte address |
| mem_rd_data_i | input | 8 | Frame memory read data, one cycle after the strobe |
| wr_valid_o | output | 1 | Byte offered to the writer |
| wr_byte_o | output | 8 | Byte to write |
| wr_a0_o | output | 1 | 0 = command byte, 1 = display data byte |
| wr_ready_i | input | 1 | Writer accepts the byte |

## Verification
On every cycle, the embedded assertions check the handshake hold rule, the column and page counters staying in range, pages advancing by one, memory reads appearing only in buffer mode, and the done pulse being a single idle cycle. Only the bench's scenarios can show that the command bytes, their order and the data values are correct. The bench compares every accepted byte against a queue built from the requirements under full-rate, irregular and long-stall ready patterns. It also shows that a start pulse during a frame and a mode change during a frame leave the byte stream untouched.

// File: rtl/pfs_pkg.sv
// Package: shared types and byte encodings for the paged frame streamer.
// Assumes page command 0xB0|page[3:0], column commands 0x10|hi and 0x00|lo.
package pfs_pkg;

    typedef enum logic [1:0] {
        SRC_BLANK  = 2'b00,
        SRC_STRIPE = 2'b01,
        SRC_BUFFER = 2'b10,
        SRC_BLANK2 = 2'b11
    } src_mode_e;

    typedef enum logic [1:0] {
        STEP_PAGE = 2'd0,
        STEP_CHI  = 2'd1,
        STEP_CLO  = 2'd2,
        STEP_DATA = 2'd3
    } step_e;

    localparam logic [7:0] OP_PAGE = 8'hB0;
    localparam logic [7:0] OP_CHI  = 8'h10;
    localparam logic [7:0] OP_CLO  = 8'h00;

    // Page command byte from a page number (low nibble only).
    function automatic logic [7:0] page_cmd(input logic [31:0] pg);
        return OP_PAGE | {4'h0, pg[3:0]};
    endfunction

    // Upper column nibble command byte.
    function automatic logic [7:0] col_hi_cmd(input logic [7:0] c);
        return OP_CHI | {4'h0, c[7:4]};
    endfunction

    // Lower column nibble command byte.
    function automatic logic [7:0] col_lo_cmd(input logic [7:0] c);
        return OP_CLO | {4'h0, c[3:0]};
    endfunction

    // Stripe byte: dark when column bit 3 is set.
    function automatic logic [7:0] stripe_byte(input logic [31:0] c);
        return c[3] ? 8'hFF : 8'h00;
    endfunction

endpackage

// File: rtl/pfs_walker.sv
// Module: pfs_walker
// Walks the frame: for every page it steps through page command, column-high
// command, column-low command and then one item per column. It offers one item
// at a time and moves on when the consumer takes it. The mode is latched on an
// accepted start. Assumes the caller holds busy_i high until the whole frame drains.
module pfs_walker
    import pfs_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int NUM_COLS  = 128,
    localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic              busy_i,
    input  logic              take_i,
    output logic              item_valid_o,
    output step_e             item_step_o,
    output logic [PAGE_W-1:0] item_page_o,
    output logic [COL_W-1:0]  item_col_o,
    output logic              item_last_o,
    output src_mode_e         mode_o
);

    localparam logic [PAGE_W-1:0] PAGE_MAX = PAGE_W'(NUM_PAGES - 1);
    localparam logic [COL_W-1:0]  COL_MAX  = COL_W'(NUM_COLS - 1);

    logic              running_q;
    step_e             step_q;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;
    src_mode_e         mode_q;
    logic              end_of_page;

    assign end_of_page  = (step_q == STEP_DATA) && (col_q == COL_MAX);
    assign item_valid_o = running_q;
    assign item_step_o  = step_q;
    assign item_page_o  = page_q;
    assign item_col_o   = col_q;
    assign item_last_o  = end_of_page && (page_q == PAGE_MAX);
    assign mode_o       = mode_q;

    // Frame position: start, then advance one item per take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            step_q    <= STEP_PAGE;
            page_q    <= '0;
            col_q     <= '0;
            mode_q    <= SRC_BLANK;
        end else if (!running_q) begin
            if (start_i && !busy_i) begin
                running_q <= 1'b1;
                step_q    <= STEP_PAGE;
                page_q    <= '0;
                col_q     <= '0;
                mode_q    <= src_mode_e'(mode_i);
            end
        end else if (take_i) begin
            unique case (step_q)
                STEP_PAGE: step_q <= STEP_CHI;
                STEP_CHI:  step_q <= STEP_CLO;
                STEP_CLO: begin
                    step_q <= STEP_DATA;
                    col_q  <= '0;
                end
                STEP_DATA: begin
                    if (col_q == COL_MAX) begin
                        col_q  <= '0;
                        step_q <= STEP_PAGE;
                        if (page_q == PAGE_MAX) begin
                            running_q <= 1'b0;
                            page_q    <= '0;
                        end else begin
                            page_q <= page_q + 1'b1;
                        end
                    end else begin
                        col_q <= col_q + 1'b1;
                    end
                end
                default: step_q <= STEP_PAGE;
            endcase
        end
    end

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (32'(col_q) < NUM_COLS)); // R3
    AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (32'(page_q) < NUM_PAGES)); // R3
    AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (running_q && take_i && end_of_page && !item_last_o)
        |=> (page_q == $past(page_q) + 1'b1) && (step_q == STEP_PAGE)); // R3
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |=> $stable(mode_q)); // R10

endmodule

// File: rtl/pfs_byte_gen.sv
// Module: pfs_byte_gen
// Turns a frame item into the byte to send: command encodings for the three
// address steps, and for data steps a blank, stripe or memory-sourced byte.
// Purely combinational. Assumes the memory address is page*NUM_COLS+col.
module pfs_byte_gen
    import pfs_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int NUM_COLS  = 128,
    localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int ADDR_W   = (NUM_PAGES * NUM_COLS > 1) ? $clog2(NUM_PAGES * NUM_COLS) : 1
) (
    input  step_e             step_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [COL_W-1:0]  col_i,
    input  src_mode_e         mode_i,
    output logic [7:0]        byte_o,
    output logic              a0_o,
    output logic              from_mem_o,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [7:0] START_COL = 8'h00;

    logic [31:0] lin_addr;

    assign lin_addr = 32'(page_i) * NUM_COLS + 32'(col_i);
    assign addr_o   = ADDR_W'(lin_addr);

    // Byte, data/command flag and memory-source flag for the current item.
    always_comb begin
        byte_o     = 8'h00;
        a0_o       = 1'b0;
        from_mem_o = 1'b0;
        unique case (step_i)
            STEP_PAGE: byte_o = page_cmd(32'(page_i));
            STEP_CHI:  byte_o = col_hi_cmd(START_COL);
            STEP_CLO:  byte_o = col_lo_cmd(START_COL);
            STEP_DATA: begin
                a0_o = 1'b1;
                unique case (mode_i)
                    SRC_STRIPE: byte_o = stripe_byte(32'(col_i));
                    SRC_BUFFER: from_mem_o = 1'b1;
                    default:    byte_o = 8'h00;
                endcase
            end
            default: byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/pfs_out_stage.sv
// Module: pfs_out_stage
// Two-register output path. Stage one holds the next item and catches the
// memory byte that arrives one cycle after its read. Stage two is the
// writer-facing register, which holds steady until ready. Stage one can hand
// over in the cycle the memory data appears, so full rate is kept.
// Assumes memory data is valid exactly one cycle after the read strobe.
module pfs_out_stage (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid_i,
    input  logic [7:0] in_byte_i,
    input  logic       in_a0_i,
    input  logic       in_mem_i,
    input  logic       in_last_i,
    output logic       take_o,
    input  logic [7:0] mem_data_i,
    output logic       wr_valid_o,
    output logic [7:0] wr_byte_o,
    output logic       wr_a0_o,
    input  logic       wr_ready_i,
    output logic       done_o,
    output logic       active_o
);

    logic       s1_valid_q;
    logic [7:0] s1_byte_q;
    logic       s1_a0_q;
    logic       s1_pend_q;
    logic       s1_last_q;
    logic       out_last_q;
    logic       s2_load;
    logic [7:0] s1_byte_now;

    assign s2_load     = s1_valid_q && (!wr_valid_o || wr_ready_i);
    assign take_o      = !s1_valid_q || s2_load;
    assign s1_byte_now = s1_pend_q ? mem_data_i : s1_byte_q;
    assign active_o    = s1_valid_q || wr_valid_o;

    // Writer-facing register: load from stage one, or empty on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_o <= 1'b0;
            wr_byte_o  <= 8'h00;
            wr_a0_o    <= 1'b0;
            out_last_q <= 1'b0;
        end else if (s2_load) begin
            wr_valid_o <= 1'b1;
            wr_byte_o  <= s1_byte_now;
            wr_a0_o    <= s1_a0_q;
            out_last_q <= s1_last_q;
        end else if (wr_ready_i) begin
            wr_valid_o <= 1'b0;
        end
    end

    // Stage one: accept a new item, or capture pending memory data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid_q <= 1'b0;
            s1_byte_q  <= 8'h00;
            s1_a0_q    <= 1'b0;
            s1_pend_q  <= 1'b0;
            s1_last_q  <= 1'b0;
        end else if (take_o) begin
            s1_valid_q <= in_valid_i;
            s1_byte_q  <= in_byte_i;
            s1_a0_q    <= in_a0_i;
            s1_pend_q  <= in_valid_i && in_mem_i;
            s1_last_q  <= in_valid_i && in_last_i;
        end else if (s1_pend_q) begin
            s1_byte_q <= mem_data_i;
            s1_pend_q <= 1'b0;
        end
    end

    // Completion pulse after the last byte is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= wr_valid_o && wr_ready_i && out_last_q;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_byte_o) && $stable(wr_a0_o))); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(wr_valid_o && wr_ready_i)); // R8

endmodule

// File: rtl/page_frame_streamer.sv
// Module: page_frame_streamer (top)
// Streams a full frame to a page-organised display controller over a byte
// writer with a command/data flag. It ties together the frame walker, the byte
// generator and the two-register output path. Assumes a synchronous frame
// memory with one cycle of read latency.
module page_frame_streamer
    import pfs_pkg::*;
#(
    parameter int NUM_PAGES = 8,
    parameter int NUM_COLS  = 128,
    localparam int PAGE_W   = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
    localparam int COL_W    = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
    localparam int ADDR_W   = (NUM_PAGES * NUM_COLS > 1) ? $clog2(NUM_PAGES * NUM_COLS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_rd_en_o,
    output logic [ADDR_W-1:0] mem_rd_addr_o,
    input  logic [7:0]        mem_rd_data_i,
    output logic              wr_valid_o,
    output logic [7:0]        wr_byte_o,
    output logic              wr_a0_o,
    input  logic              wr_ready_i
);

    logic              item_valid;
    step_e             item_step;
    logic [PAGE_W-1:0] item_page;
    logic [COL_W-1:0]  item_col;
    logic              item_last;
    src_mode_e         frame_mode;
    logic [7:0]        gen_byte;
    logic              gen_a0;
    logic              gen_mem;
    logic              take;
    logic              out_active;

    assign busy_o      = item_valid || out_active;
    assign mem_rd_en_o = item_valid && take && gen_mem;

    pfs_walker #(.NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS)) walker_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .busy_i       (busy_o),
        .take_i       (take),
        .item_valid_o (item_valid),
        .item_step_o  (item_step),
        .item_page_o  (item_page),
        .item_col_o   (item_col),
        .item_last_o  (item_last),
        .mode_o       (frame_mode)
    );

    pfs_byte_gen #(.NUM_PAGES(NUM_PAGES), .NUM_COLS(NUM_COLS)) gen_i (
        .step_i     (item_step),
        .page_i     (item_page),
        .col_i      (item_col),
        .mode_i     (frame_mode),
        .byte_o     (gen_byte),
        .a0_o       (gen_a0),
        .from_mem_o (gen_mem),
        .addr_o     (mem_rd_addr_o)
    );

    pfs_out_stage out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid_i (item_valid),
        .in_byte_i  (gen_byte),
        .in_a0_i    (gen_a0),
        .in_mem_i   (gen_mem),
        .in_last_i  (item_last),
        .take_o     (take),
        .mem_data_i (mem_rd_data_i),
        .wr_valid_o (wr_valid_o),
        .wr_byte_o  (wr_byte_o),
        .wr_a0_o    (wr_a0_o),
        .wr_ready_i (wr_ready_i),
        .done_o     (done_o),
        .active_o   (out_active)
    );

    AST_RD_BUFFER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |-> (frame_mode == SRC_BUFFER)); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8
    AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(frame_mode)); // R9
    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R8

endmodule

// File: tb/page_frame_streamer_tb.sv
module page_frame_streamer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PAGES = 3;
    localparam int COLS  = 20;
    localparam int AW    = $clog2(PAGES * COLS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic          busy_o, done_o, mem_rd_en_o;
    logic [AW-1:0] mem_rd_addr_o;
    logic [7:0]    mem_rd_data_i = 8'h00;
    logic          wr_valid_o, wr_a0_o;
    logic [7:0]    wr_byte_o;
    logic          wr_ready_i = 1'b0;

    int tests = 0;
    int fails = 0;
    logic [8:0] expq[$];
    int   ready_style = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [1:0] cur_mode = 2'b00;
    logic done_exp = 1'b0;
    logic frame_done_seen = 1'b0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_byte = 8'h00;
    logic prev_a0 = 1'b0;
    int   stall_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_frame_streamer #(.NUM_PAGES(PAGES), .NUM_COLS(COLS)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .busy_o(busy_o), .done_o(done_o), .mem_rd_en_o(mem_rd_en_o),
        .mem_rd_addr_o(mem_rd_addr_o), .mem_rd_data_i(mem_rd_data_i),
        .wr_valid_o(wr_valid_o), .wr_byte_o(wr_byte_o), .wr_a0_o(wr_a0_o),
        .wr_ready_i(wr_ready_i)
    );

    function automatic logic [7:0] mem_val(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    // Frame memory model: one cycle read latency.
    always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem_val(int'(mem_rd_addr_o));

    task automatic check(input logic ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Ready driver: full rate, irregular, or long stalls.
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        stall_cnt = (stall_cnt + 1) % 9;
        case (ready_style)
            0: wr_ready_i = 1'b1;
            1: wr_ready_i = lfsr[0] | lfsr[3];
            default: wr_ready_i = (stall_cnt == 0);
        endcase
    end

    // Monitor: compare every handshake and timing rule at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o || done_exp)
                check(done_o == done_exp, "R8 done timing", int'(done_o), int'(done_exp));
            if (done_o) begin
                check(!busy_o, "R8 busy low at done", int'(busy_o), 0);
                frame_done_seen = 1'b1;
            end
            done_exp = 1'b0;
            if (cur_mode != 2'b10 && mem_rd_en_o)
                check(1'b0, "R6 read outside buffer mode", 1, 0);
            if (prev_stall)
                check(wr_valid_o && wr_byte_o == prev_byte && wr_a0_o == prev_a0,
                      "R7 hold", {wr_valid_o, wr_a0_o, wr_byte_o}, {1'b1, prev_a0, prev_byte});
            prev_stall = wr_valid_o && !wr_ready_i;
            prev_byte  = wr_byte_o;
            prev_a0    = wr_a0_o;
            if (wr_valid_o && wr_ready_i) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R3 extra byte", {wr_a0_o, wr_byte_o}, 0);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    check({wr_a0_o, wr_byte_o} == e,
                          e[8] ? "R2/R4/R5/R6 data byte" : "R2/R3 command byte",
                          {wr_a0_o, wr_byte_o}, e);
                    if (expq.size() == 0) done_exp = 1'b1;
                end
            end
        end
    end

    // Expected frame: page cmd, column hi/lo, then per-column data.
    task automatic build_frame(input logic [1:0] m);
        for (int p = 0; p < PAGES; p++) begin
            expq.push_back({1'b0, 8'hB0 | 8'(p & 15)});
            expq.push_back({1'b0, 8'h10});
            expq.push_back({1'b0, 8'h00});
            for (int c = 0; c < COLS; c++) begin
                logic [7:0] d;
                case (m)
                    2'b01:   d = ((c / 8 + 2) % 2 == 1) ? 8'hFF : 8'h00;
                    2'b10:   d = mem_val(p * COLS + c);
                    default: d = 8'h00;
                endcase
                expq.push_back({1'b1, d});
            end
        end
    endtask

    // Run one frame; optionally disturb it with a start or mode change mid-frame.
    task automatic run_frame(input logic [1:0] m, input int style, input bit disturb);
        int n;
        ready_style = style;
        @(posedge clk); #2;
        build_frame(m);
        cur_mode = m;
        frame_done_seen = 1'b0;
        mode_i = m;
        start_i = 1'b1;
        @(posedge clk); #2;
        start_i = 1'b0;
        @(negedge clk);
        check(busy_o, "R8 busy after start", int'(busy_o), 1);
        if (disturb) begin
            repeat (15) @(posedge clk);
            #2;
            mode_i = ~m;            // R10: mode change mid-frame
            start_i = 1'b1;         // R9: start while busy
            @(posedge clk); #2;
            start_i = 1'b0;
        end
        n = 0;
        while (!frame_done_seen && n < 5000) begin
            @(posedge clk);
            n++;
        end
        @(negedge clk);
        check(frame_done_seen, "R8 done seen", int'(frame_done_seen), 1);
        check(expq.size() == 0, "R3 frame length", expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wr_valid_o && !done_o && !busy_o && !mem_rd_en_o, "R1 reset state",
              {wr_valid_o, done_o, busy_o, mem_rd_en_o}, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        @(negedge clk);
        check(!wr_valid_o && !done_o && !busy_o && !mem_rd_en_o, "R1 after reset",
              {wr_valid_o, done_o, busy_o, mem_rd_en_o}, 0);
        run_frame(2'b00, 0, 1'b0);   // R4 blank, full rate
        run_frame(2'b01, 1, 1'b0);   // R5 stripe, irregular ready
        run_frame(2'b10, 0, 1'b0);   // R6 buffer, full rate
        run_frame(2'b10, 1, 1'b0);   // R6 buffer, irregular ready
        run_frame(2'b10, 2, 1'b0);   // R7 buffer, long stalls
        run_frame(2'b11, 2, 1'b0);   // R4 code 11 behaves as blank
        run_frame(2'b01, 1, 1'b1);   // R9 R10 disturbed stripe frame
        run_frame(2'b10, 1, 1'b1);   // R9 R10 disturbed buffer frame
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !wr_valid_o, "R9 no restart after frame", {busy_o, wr_valid_o}, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule